// File: doc/BRIEF.md
# Tuner Status Readout Shifter with Gated IF Counter

This block counts rising edges on an intermediate-frequency logic input during a timed gate window. When a host controller asks for status, the block returns that count together with a lock flag and the levels of two general I/O pins. The host uses a three-wire synchronous link made of a chip-enable, a serial clock and a data-out line. A one-cycle start strobe clears the 20-bit counter and opens the window. A 2-bit select sets the window length to 1, 4, 8 or 32 milliseconds. The counter stops at all ones and does not wrap.

When chip-enable rises with the read-mode input high, the block copies a 23-bit snapshot into a shadow register. Each falling edge of the serial clock moves the frame forward by one bit, so the host can sample on rising edges. All serial inputs are sampled by the block clock, and edges are detected on that clock. While chip-enable is low, the data line rests high and the bit pointer returns to the start.

Two state machines do the work. The gate machine has two states. `GC_IDLE` moves to `GC_COUNT` when the start strobe arrives. `GC_COUNT` restarts itself on a new strobe, and moves back to `GC_IDLE` when the gate timer runs out. The link machine has four states. From `SH_IDLE`, a chip-enable rise goes to `SH_SHIFT` in read mode, or to `SH_INPUT` when read mode is low. `SH_SHIFT` moves to `SH_DONE` on the clock fall that follows the last bit. `SH_SHIFT`, `SH_DONE` and `SH_INPUT` all return to `SH_IDLE` when chip-enable falls.

Top module: `tuner_status_shifter`

## Requirements
- R1: While `ser_cs` is low, `ser_dout` is high.
- R2: A read frame is 23 bits long, sent in this order: `io_pins[1]`, then `io_pins[0]`, then the lock flag, then count bits 19 down to 0. The first bit appears one block clock after `ser_cs` rises. Each later bit appears one block clock after a falling edge of `ser_clk`.
- R3: The pin levels, the lock flag and the count are captured at the `ser_cs` rise. Changes on those inputs during the transfer do not alter the frame.
- R4: The lock bit in the frame is 1 when `lock_in` is high (locked, or detection stopped) and 0 when it is low (unlocked).
- R5: A `cnt_start` pulse clears the count. It then opens a window of L block clocks, with L = CYC_PER_MS × {1, 4, 8, 32} for `gate_sel` = 0, 1, 2, 3. A rise of `if_in` is counted when `if_in` is seen high at one of the L edges that follow the strobe, after being seen low at the edge before. A new strobe during a window restarts both the count and the window.
- R6: Rises of `if_in` after the window has closed leave the count unchanged.
- R7: The count holds at all ones (2^CNT_W − 1) and does not wrap.
- R8: A `ser_cs` rise while `rd_mode` is low starts no frame. `ser_dout` stays high for the whole transfer.
- R9: After the last frame bit, further `ser_clk` falls give a high `ser_dout`. Lowering `ser_cs` resets the pointer, so the next read starts again from `io_pins[1]`.
- R10: After reset the count is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| if_in | input | 1 | IF signal as a logic level |
| cnt_start | input | 1 | One-cycle strobe that clears the count and opens the gate window |
| gate_sel | input | 2 | Gate length select: 0 = 1 ms, 1 = 4 ms, 2 = 8 ms, 3 = 32 ms |
| lock_in | input | 1 | Lock detector level: 1 = locked or stopped, 0 = unlocked |
| io_pins | input | 2 | Levels of the two general I/O pins |
| ser_cs | input | 1 | Serial chip-enable |
| ser_clk | input | 1 | Serial clock; bits advance on its falling edge |
| rd_mode | input | 1 | 1 = status read transfer, 0 = any other transfer |
| ser_dout | output | 1 | Serial data out; high when idle |

## Verification
A table of vectors runs gates of every length against pulse trains of different lengths. Short trains test exact counting, and trains longer than the window test the cut-off at L edges. Each vector also sets its own pin and lock levels, which exposes swapped or misordered header bits, and an all-zero count checks that no bits are left over. Directed cases cover the following:
- a restart in the middle of a window, which shows the clear;
- input changes during shifting, which show the snapshot;
- a read with `rd_mode` low, and extra clocks after the last bit;
- a narrow-counter instance that is driven into saturation.

// File: rtl/tss_pkg.sv
package tss_pkg;

    typedef enum logic {
        GC_IDLE  = 1'b0,
        GC_COUNT = 1'b1
    } gate_state_t;

    typedef enum logic [1:0] {
        SH_IDLE  = 2'd0,
        SH_SHIFT = 2'd1,
        SH_DONE  = 2'd2,
        SH_INPUT = 2'd3
    } link_state_t;

    // Window length in milliseconds for each select code
    function automatic int gate_ms(input logic [1:0] sel);
        case (sel)
            2'd0:    return 1;
            2'd1:    return 4;
            2'd2:    return 8;
            default: return 32;
        endcase
    endfunction

endpackage

// File: rtl/tss_gate_counter.sv
module tss_gate_counter
    import tss_pkg::*;
#(
    parameter int CNT_W      = 20,
    parameter int CYC_PER_MS = 1000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             if_in,
    input  logic             cnt_start,
    input  logic [1:0]       gate_sel,
    output logic [CNT_W-1:0] count
);
    localparam int              TMR_W   = $clog2(32 * CYC_PER_MS + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    gate_state_t      state_q, state_d;
    logic [TMR_W-1:0] timer_q;
    logic [CNT_W-1:0] count_q;
    logic             if_q;
    logic             if_rise;
    logic [TMR_W-1:0] gate_len_m1;

    assign if_rise     = if_in & ~if_q;
    assign gate_len_m1 = TMR_W'(gate_ms(gate_sel) * CYC_PER_MS - 1);

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GC_IDLE:  if (cnt_start) state_d = GC_COUNT;
            GC_COUNT: if (!cnt_start && timer_q == '0) state_d = GC_IDLE;
            default:  state_d = GC_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= GC_IDLE;
        else        state_q <= state_d;
    end

    // Timer, edge history and count
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            timer_q <= '0;
            count_q <= '0;
            if_q    <= 1'b0;
        end else begin
            if_q <= if_in;
            if (cnt_start) begin
                timer_q <= gate_len_m1;
                count_q <= '0;
            end else if (state_q == GC_COUNT) begin
                if (timer_q != '0) timer_q <= timer_q - 1'b1;
                if (if_rise && count_q != CNT_MAX) count_q <= count_q + 1'b1;
            end
        end
    end

    assign count = count_q;

    AST_CNT_CLEAR:   assert property (@(posedge clk) disable iff (!rst_n)
        cnt_start |=> (count_q == '0)); // R5
    AST_CNT_STEP:    assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_start && state_q == GC_COUNT && count_q != CNT_MAX)
            |=> (count_q - $past(count_q) <= 1)); // R5
    AST_CNT_CLOSED:  assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == GC_IDLE && !cnt_start) |=> $stable(count_q)); // R6
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (count_q == CNT_MAX && !cnt_start) |=> (count_q == CNT_MAX)); // R7

endmodule

// File: rtl/tss_serializer.sv
module tss_serializer
    import tss_pkg::*;
#(
    parameter int FRAME_W = 23
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ser_cs,
    input  logic               ser_clk,
    input  logic               rd_mode,
    input  logic [FRAME_W-1:0] frame_in,
    output logic               ser_dout
);
    localparam int                PTR_W    = $clog2(FRAME_W);
    localparam logic [PTR_W-1:0] LAST_BIT = PTR_W'(FRAME_W - 1);

    link_state_t        state_q, state_d;
    logic [FRAME_W-1:0] shadow_q;
    logic [PTR_W-1:0]   ptr_q;
    logic               cs_q, sclk_q;
    logic               cs_rise, sclk_fall;

    assign cs_rise   = ser_cs & ~cs_q;
    assign sclk_fall = ~ser_clk & sclk_q;

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SH_IDLE:  if (cs_rise) state_d = rd_mode ? SH_SHIFT : SH_INPUT;
            SH_SHIFT: begin
                if (!ser_cs)                            state_d = SH_IDLE;
                else if (sclk_fall && ptr_q == LAST_BIT) state_d = SH_DONE;
            end
            SH_DONE:  if (!ser_cs) state_d = SH_IDLE;
            SH_INPUT: if (!ser_cs) state_d = SH_IDLE;
            default:  state_d = SH_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SH_IDLE;
        else        state_q <= state_d;
    end

    // Snapshot, shift and pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shadow_q <= '0;
            ptr_q    <= '0;
            cs_q     <= 1'b0;
            sclk_q   <= 1'b0;
        end else begin
            cs_q   <= ser_cs;
            sclk_q <= ser_clk;
            if (!ser_cs) begin
                ptr_q <= '0;
            end else if (state_q == SH_IDLE && cs_rise && rd_mode) begin
                shadow_q <= frame_in;
                ptr_q    <= '0;
            end else if (state_q == SH_SHIFT && sclk_fall) begin
                shadow_q <= shadow_q << 1;
                if (ptr_q != LAST_BIT) ptr_q <= ptr_q + 1'b1;
            end
        end
    end

    // Output decode
    always_comb begin
        ser_dout = 1'b1;
        if (state_q == SH_SHIFT && ser_cs) ser_dout = shadow_q[FRAME_W-1];
    end

    AST_LOAD_START:  assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SH_IDLE && cs_rise && rd_mode)
            |=> (state_q == SH_SHIFT && ptr_q == '0)); // R2
    AST_PTR_RANGE:   assert property (@(posedge clk) disable iff (!rst_n)
        ptr_q <= LAST_BIT); // R2
    AST_SNAP_HOLD:   assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SH_SHIFT && !sclk_fall && ser_cs) |=> $stable(shadow_q)); // R3
    AST_INPUT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SH_INPUT) |-> ser_dout); // R8
    AST_CS_DROP:     assert property (@(posedge clk) disable iff (!rst_n)
        (!ser_cs) |=> (state_q == SH_IDLE && ptr_q == '0)); // R9

endmodule

// File: rtl/tuner_status_shifter.sv
module tuner_status_shifter
    import tss_pkg::*;
#(
    parameter int CNT_W      = 20,
    parameter int CYC_PER_MS = 1000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       if_in,
    input  logic       cnt_start,
    input  logic [1:0] gate_sel,
    input  logic       lock_in,
    input  logic [1:0] io_pins,
    input  logic       ser_cs,
    input  logic       ser_clk,
    input  logic       rd_mode,
    output logic       ser_dout
);
    localparam int FRAME_W = CNT_W + 3;

    logic [CNT_W-1:0]   count;
    logic [FRAME_W-1:0] frame;

    tss_gate_counter #(
        .CNT_W      (CNT_W),
        .CYC_PER_MS (CYC_PER_MS)
    ) u_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .if_in     (if_in),
        .cnt_start (cnt_start),
        .gate_sel  (gate_sel),
        .count     (count)
    );

    // Frame order: pin 2, pin 1, lock flag, count MSB first
    assign frame = {io_pins[1], io_pins[0], lock_in, count};

    tss_serializer #(
        .FRAME_W (FRAME_W)
    ) u_serial (
        .clk      (clk),
        .rst_n    (rst_n),
        .ser_cs   (ser_cs),
        .ser_clk  (ser_clk),
        .rd_mode  (rd_mode),
        .frame_in (frame),
        .ser_dout (ser_dout)
    );

    AST_RESET_COUNT: assert property (@(posedge clk)
        $rose(rst_n) |-> (count == '0)); // R10

endmodule

// File: tb/tuner_status_shifter_tb.sv
module tuner_status_shifter_tb;
    localparam int CPM   = 16;
    localparam int SAT_W = 4;
    localparam int NVEC  = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic if_in = 1'b0, cnt_start = 1'b0, lock_in = 1'b0;
    logic [1:0] gate_sel = 2'd0, io_pins = 2'd0;
    logic ser_cs = 1'b0, ser_clk = 1'b0, rd_mode = 1'b1;
    logic ser_dout, sat_dout;

    int checks = 0;
    int errors = 0;
    logic [22:0] got;
    logic [6:0]  got_s;
    logic [24:0] extra;

    always #2 clk = ~clk;

    tuner_status_shifter #(.CNT_W(20), .CYC_PER_MS(CPM)) u_dut (
        .clk(clk), .rst_n(rst_n), .if_in(if_in), .cnt_start(cnt_start),
        .gate_sel(gate_sel), .lock_in(lock_in), .io_pins(io_pins),
        .ser_cs(ser_cs), .ser_clk(ser_clk), .rd_mode(rd_mode), .ser_dout(ser_dout));

    tuner_status_shifter #(.CNT_W(SAT_W), .CYC_PER_MS(CPM)) u_dut_sat (
        .clk(clk), .rst_n(rst_n), .if_in(if_in), .cnt_start(cnt_start),
        .gate_sel(gate_sel), .lock_in(lock_in), .io_pins(io_pins),
        .ser_cs(ser_cs), .ser_clk(ser_clk), .rd_mode(rd_mode), .ser_dout(sat_dout));

    // Vector: {gate_sel[1:0], pulses[7:0], pins[1:0], lock}
    localparam logic [12:0] VEC [NVEC] = '{
        {2'd0, 8'd3,   2'b10, 1'b1},
        {2'd0, 8'd20,  2'b01, 1'b0},
        {2'd1, 8'd31,  2'b11, 1'b1},
        {2'd2, 8'd0,   2'b00, 1'b0},
        {2'd3, 8'd200, 2'b10, 1'b1},
        {2'd1, 8'd40,  2'b01, 1'b1}
    };

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int win_len(input logic [1:0] sel);
        case (sel)
            2'd0: return CPM;
            2'd1: return 4 * CPM;
            2'd2: return 8 * CPM;
            default: return 32 * CPM;
        endcase
    endfunction

    function automatic int exp_count(input logic [1:0] sel, input int n, input int w);
        int c = n;
        if (c > (win_len(sel) + 1) / 2) c = (win_len(sel) + 1) / 2;
        if (c > (1 << w) - 1) c = (1 << w) - 1;
        return c;
    endfunction

    // Strobe, then n one-cycle pulses, then let the window close
    task automatic run_gate(input logic [1:0] sel, input int n);
        gate_sel = sel;
        cnt_start = 1'b1;
        tick();
        cnt_start = 1'b0;
        for (int k = 0; k < n; k++) begin
            if_in = 1'b1; tick();
            if_in = 1'b0; tick();
        end
        repeat (win_len(sel) + 4) tick();
    endtask

    // Read frame; nb samples; optionally disturb inputs after load
    task automatic read_frame(input int nb, input bit disturb);
        rd_mode = 1'b1;
        ser_cs = 1'b1;
        tick();
        got = '0; got_s = '0; extra = '0;
        if (disturb) begin
            io_pins = ~io_pins;
            lock_in = ~lock_in;
            cnt_start = 1'b1; tick(); cnt_start = 1'b0;
        end
        for (int b = 0; b < nb; b++) begin
            extra = {extra[23:0], ser_dout};
            if (b < 23) got = {got[21:0], ser_dout};
            if (b < 7) got_s = {got_s[5:0], sat_dout};
            ser_clk = 1'b1; tick();
            ser_clk = 1'b0; tick();
        end
        ser_cs = 1'b0;
        tick();
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        logic [1:0] sel;
        int n, ec;
        logic [22:0] exp;
        repeat (3) tick();
        // R1: idle line high during reset and after
        chk(ser_dout == 1'b1, "R1 idle high in reset", ser_dout, 1);
        rst_n = 1'b1;
        tick();
        chk(ser_dout == 1'b1, "R1 idle high after reset", ser_dout, 1);

        // R10: count zero after reset
        io_pins = 2'b11; lock_in = 1'b0;
        read_frame(23, 1'b0);
        chk(got == {2'b11, 1'b0, 20'd0}, "R10 reset count zero", got, {2'b11, 1'b0, 20'd0});

        // Vector table: R2 order, R4 lock, R5 window, R6 cut-off
        for (int v = 0; v < NVEC; v++) begin
            sel = VEC[v][12:11];
            n = int'(VEC[v][10:3]);
            run_gate(sel, n);
            io_pins = VEC[v][2:1];
            lock_in = VEC[v][0];
            ec = exp_count(sel, n, 20);
            exp = {VEC[v][2:1], VEC[v][0], 20'(ec)};
            read_frame(23, 1'b0);
            chk(got == exp, "R2 R4 R5 R6 vector frame", got, exp);
        end

        // R7: narrow instance saturates (count from last vector: 32 rises)
        chk(got_s == {2'b01, 1'b1, 4'hF}, "R7 saturation", got_s, {2'b01, 1'b1, 4'hF});

        // R5: restart mid-window clears and reopens
        gate_sel = 2'd1;
        cnt_start = 1'b1; tick(); cnt_start = 1'b0;
        for (int k = 0; k < 5; k++) begin if_in = 1'b1; tick(); if_in = 1'b0; tick(); end
        run_gate(2'd1, 3);
        io_pins = 2'b00; lock_in = 1'b1;
        read_frame(23, 1'b0);
        chk(got == {2'b00, 1'b1, 20'd3}, "R5 restart clears", got, {2'b00, 1'b1, 20'd3});

        // R6: pulses after window leave count unchanged
        for (int k = 0; k < 10; k++) begin if_in = 1'b1; tick(); if_in = 1'b0; tick(); end
        read_frame(23, 1'b0);
        chk(got == {2'b00, 1'b1, 20'd3}, "R6 closed window", got, {2'b00, 1'b1, 20'd3});

        // R3: inputs and count disturbed during shift; snapshot kept
        io_pins = 2'b10; lock_in = 1'b0;
        read_frame(23, 1'b1);
        chk(got == {2'b10, 1'b0, 20'd3}, "R3 snapshot held", got, {2'b10, 1'b0, 20'd3});

        // R4: lock low reads 0, high reads 1
        io_pins = 2'b00; lock_in = 1'b0;
        read_frame(23, 1'b0);
        chk(got[20] == 1'b0, "R4 unlocked bit", got[20], 0);
        lock_in = 1'b1;
        read_frame(23, 1'b0);
        chk(got[20] == 1'b1, "R4 locked bit", got[20], 1);

        // R9: bits past the frame are high; next read restarts at pin 2
        io_pins = 2'b10; lock_in = 1'b0;
        read_frame(25, 1'b0);
        chk(extra[1:0] == 2'b11, "R9 past end high", extra[1:0], 3);
        io_pins = 2'b10;
        read_frame(23, 1'b0);
        chk(got[22:21] == 2'b10, "R9 restart at first bit", got[22:21], 2);

        // R8: read mode low gives no frame
        io_pins = 2'b00; lock_in = 1'b0;
        rd_mode = 1'b0; ser_cs = 1'b1; tick();
        for (int b = 0; b < 6; b++) begin
            chk(ser_dout == 1'b1, "R8 non-read transfer high", ser_dout, 1);
            ser_clk = 1'b1; tick(); ser_clk = 1'b0; tick();
        end
        ser_cs = 1'b0; tick();
        chk(ser_dout == 1'b1, "R1 idle high after transfer", ser_dout, 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule